// File: doc/BRIEF.md
# Self-Timed Memory Port Pulse Generator

This block models the self-timed control of one memory port in cycle-accurate form. A fast sampling clock shifts the gated port clock down a register line that stands in for an inverter delay chain. Five taps are taken from that line. A tap at an odd stage count is inverted, which models the polarity of an inverter chain. The tap positions are fixed at elaboration from two integer stage budgets: one for the precharge duration and one for the bitline settling time.

Three overlap windows are formed as two-input NANDs of tap pairs, one of which uses the live gated clock. These windows drive four port strobes: an active-low precharge enable, a wordline enable, a sense-amplifier enable and a write-driver enable. A parameter selects a read-write port or a single-direction port, and this choice decides which inputs qualify the sense and write strobes. Physical delay, buffer sizing and the array itself are not modelled.

Top module: `stc_pulse_gen`

## Requirements
- R1: The tap positions, in stages, are as follows. Tap 0 is 2. Tap 2 is 2 plus PRECH_STAGES, rounded up to the next odd integer. Tap 1 is tap 2 minus 1. Tap 3 is tap 2 plus 2. Tap 4 is tap 3 plus SETTLE_STAGES, rounded up to the next odd integer.
- R2: A tap at P stages equals the gated clock as sampled P sample-clock edges earlier. It is inverted when P is odd.
- R3: While reset is asserted (rst_n low), every tap holds its at-rest value for a low input: 0 for even positions and 1 for odd positions. The outputs follow from these values.
- R4: pchg_n equals NAND(tap 0, tap 2).
- R5: wl_en equals cs AND NAND(gclk, tap 3), so wl_en is low whenever cs is low.
- R6: sa_en is the AND of NAND(tap 1, tap 4), gclk_n and a qualifier. The qualifier is NOT we when RW_PORT=1 and cs when RW_PORT=0.
- R7: wr_en is the AND of a qualifier, NAND(gclk, tap 3) and NOT NAND(tap 1, tap 4). The qualifier is we when RW_PORT=1 and cs when RW_PORT=0. As a result, wr_en and sa_en are never high together.
- R8: When RW_PORT=0, the we input has no effect on any output.
- R9: Taps 0 and 1 are at even positions and taps 2 to 4 are at odd positions. Tap 2 follows tap 1 by exactly one stage, with opposite polarity.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock that advances the delay line |
| rst_n | input | 1 | Asynchronous active-low reset |
| gclk | input | 1 | Gated port clock, buffered (chain input) |
| gclk_n | input | 1 | Gated port clock, complement |
| cs | input | 1 | Chip select |
| we | input | 1 | Write enable (used only when RW_PORT=1) |
| pchg_n | output | 1 | Precharge enable, active low |
| wl_en | output | 1 | Wordline enable |
| sa_en | output | 1 | Sense-amplifier enable |
| wr_en | output | 1 | Write-driver enable |

## Verification
The assertions check the following on every cycle: the two-stage delay of tap 0, the one-stage step and polarity flip from tap 1 to tap 2, the two-stage spacing from tap 2 to tap 3, the blocking of wl_en by a low cs, the exclusion between sa_en and wr_en, and on a single-direction port the blocking of sa_en and wr_en by a low cs. Only the bench scenarios can show that the positions of taps 1 and 4, and the rounding of odd budgets, come out as required. The bench does this with a long pseudo-random sweep of the gated clock, cs and we on two configurations, comparing every strobe with a model built from the tap formulas. The same sweep covers the reset values and the fact that we has no effect on a single-direction port.

// File: rtl/stc_pkg.sv
package stc_pkg;

    localparam int NUM_TAPS = 5;
    localparam int KEEPOUT  = 2;

    typedef logic [NUM_TAPS-1:0] tap_vec_t;

    // next odd integer at or above v
    function automatic int odd_ceil(input int v);
        return (v % 2 == 0) ? v + 1 : v;
    endfunction

    // stage position of tap idx from the two stage budgets
    function automatic int tap_pos(input int idx, input int prech, input int settle);
        int p2;
        int p3;
        int p4;
        p2 = odd_ceil(KEEPOUT + prech);
        p3 = p2 + 2;
        p4 = odd_ceil(p3 + settle);
        case (idx)
            0:       return KEEPOUT;
            1:       return p2 - 1;
            2:       return p2;
            3:       return p3;
            default: return p4;
        endcase
    endfunction

endpackage

// File: rtl/stc_tap_chain.sv
module stc_tap_chain
    import stc_pkg::*;
#(
    parameter int PRECH_STAGES  = 3,
    parameter int SETTLE_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     chain_in,
    output tap_vec_t taps
);

    localparam int DEPTH = tap_pos(NUM_TAPS - 1, PRECH_STAGES, SETTLE_STAGES);

    typedef struct packed {
        logic [DEPTH-1:0] line;
    } chain_t;

    chain_t st_d;
    chain_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.line = {st_q.line[DEPTH-2:0], chain_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // each tap reads line cell P-1 and inverts when P is odd
    for (genvar n = 0; n < NUM_TAPS; n++) begin : g_tap
        localparam int P = tap_pos(n, PRECH_STAGES, SETTLE_STAGES);
        localparam logic INV = (P % 2 == 1);
        assign taps[n] = st_q.line[P-1] ^ INV;
    end

endmodule

// File: rtl/stc_strobe_logic.sv
module stc_strobe_logic
    import stc_pkg::*;
#(
    parameter bit RW_PORT = 1'b1
) (
    input  tap_vec_t taps,
    input  logic     gclk,
    input  logic     gclk_n,
    input  logic     cs,
    input  logic     we,
    output logic     pchg_n,
    output logic     wl_en,
    output logic     sa_en,
    output logic     wr_en
);

    logic win0;
    logic win1;
    logic win2;
    logic sense_qual;
    logic write_qual;

    always_comb begin
        win0 = ~(taps[0] & taps[2]);
        win1 = ~(gclk & taps[3]);
        win2 = ~(taps[1] & taps[4]);
    end

    if (RW_PORT) begin : g_rw
        assign sense_qual = ~we;
        assign write_qual = we;
    end else begin : g_single
        assign sense_qual = cs;
        assign write_qual = cs;
    end

    always_comb begin
        pchg_n = win0;
        wl_en  = cs & win1;
        sa_en  = win2 & gclk_n & sense_qual;
        wr_en  = write_qual & win1 & ~win2;
    end

endmodule

// File: rtl/stc_pulse_gen.sv
module stc_pulse_gen
    import stc_pkg::*;
#(
    parameter int PRECH_STAGES  = 3,
    parameter int SETTLE_STAGES = 2,
    parameter bit RW_PORT       = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gclk,
    input  logic gclk_n,
    input  logic cs,
    input  logic we,
    output logic pchg_n,
    output logic wl_en,
    output logic sa_en,
    output logic wr_en
);

    tap_vec_t taps;

    stc_tap_chain #(
        .PRECH_STAGES (PRECH_STAGES),
        .SETTLE_STAGES(SETTLE_STAGES)
    ) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .chain_in(gclk),
        .taps    (taps)
    );

    stc_strobe_logic #(
        .RW_PORT(RW_PORT)
    ) u_strobe (
        .taps  (taps),
        .gclk  (gclk),
        .gclk_n(gclk_n),
        .cs    (cs),
        .we    (we),
        .pchg_n(pchg_n),
        .wl_en (wl_en),
        .sa_en (sa_en),
        .wr_en (wr_en)
    );

endmodule

// File: rtl/stc_pulse_gen_chk.sv
module stc_pulse_gen_chk
    import stc_pkg::*;
#(
    parameter bit RW_PORT = 1'b1
) (
    input logic     clk,
    input logic     rst_n,
    input logic     gclk,
    input logic     cs,
    input logic     wl_en,
    input logic     sa_en,
    input logic     wr_en,
    input tap_vec_t taps
);

    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    p_tap0_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (taps[0] == $past(gclk, 2)));

    p_tap_parity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd1) |-> (taps[2] == !$past(taps[1])));

    p_tap3_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 2'd2) |-> (taps[3] == $past(taps[2], 2)));

    p_wl_needs_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !wl_en);

    p_sense_write_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sa_en && wr_en));

    if (!RW_PORT) begin : g_single
        p_single_cs_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !cs |-> (!sa_en && !wr_en));
    end

endmodule

bind stc_pulse_gen stc_pulse_gen_chk #(.RW_PORT(RW_PORT)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .gclk (gclk),
    .cs   (cs),
    .wl_en(wl_en),
    .sa_en(sa_en),
    .wr_en(wr_en),
    .taps (taps)
);

// File: tb/sim_stc_pulse_gen.sv
module sim_stc_pulse_gen;

    localparam int STEPS = 600;
    // configuration A: read-write, budgets give tap2 = 5 without rounding
    localparam int PA = 3;
    localparam int SA = 2;
    // configuration B: single-direction, both roundings active
    localparam int PB = 4;
    localparam int SB = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gclk = 1'b0;
    logic gclk_n = 1'b1;
    logic cs = 1'b0;
    logic we = 1'b0;
    logic pa_n, wla, saa, wra;
    logic pb_n, wlb, sab, wrb;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    int hist [0:STEPS-1];

    always #4 clk = ~clk;

    stc_pulse_gen #(.PRECH_STAGES(PA), .SETTLE_STAGES(SA), .RW_PORT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .gclk(gclk), .gclk_n(gclk_n), .cs(cs), .we(we),
        .pchg_n(pa_n), .wl_en(wla), .sa_en(saa), .wr_en(wra)
    );

    stc_pulse_gen #(.PRECH_STAGES(PB), .SETTLE_STAGES(SB), .RW_PORT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .gclk(gclk), .gclk_n(gclk_n), .cs(cs), .we(we),
        .pchg_n(pb_n), .wl_en(wlb), .sa_en(sab), .wr_en(wrb)
    );

    function automatic int odd_up(input int v);
        return (v % 2 == 0) ? v + 1 : v;
    endfunction

    // R1: tap positions from the stage budgets
    function automatic int pos_of(input int idx, input int pr, input int st);
        int t2;
        t2 = odd_up(2 + pr);
        case (idx)
            0:       return 2;
            1:       return t2 - 1;
            2:       return t2;
            3:       return t2 + 2;
            default: return odd_up(t2 + 2 + st);
        endcase
    endfunction

    // R2: value of a tap at stage p after step s (-1 means reset)
    function automatic bit tap_val(input int p, input int s);
        int k;
        bit v;
        k = s + 1 - p;
        v = (k >= 0) ? hist[k][0] : 1'b0;
        return v ^ bit'(p % 2);
    endfunction

    task automatic chk(input bit act, input bit exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    task automatic check_cfg(input int s, input int pr, input int st, input bit rw,
                             input bit o_p, input bit o_wl, input bit o_sa, input bit o_wr,
                             input string tag);
        bit t0, t1, t2, t3, t4, w0, w1, w2, sq, wq;
        t0 = tap_val(pos_of(0, pr, st), s);
        t1 = tap_val(pos_of(1, pr, st), s);
        t2 = tap_val(pos_of(2, pr, st), s);
        t3 = tap_val(pos_of(3, pr, st), s);
        t4 = tap_val(pos_of(4, pr, st), s);
        w0 = ~(t0 & t2);
        w1 = ~(gclk & t3);
        w2 = ~(t1 & t4);
        sq = rw ? ~we : cs;
        wq = rw ? we : cs;
        chk(o_p, w0, $sformatf("R4 R1 R2 R3 %s pchg_n step %0d", tag, s));
        chk(o_wl, cs & w1, $sformatf("R5 R1 %s wl_en step %0d", tag, s));
        chk(o_sa, w2 & gclk_n & sq, $sformatf("R6 R8 R9 %s sa_en step %0d", tag, s));
        chk(o_wr, wq & w1 & ~w2, $sformatf("R7 R8 %s wr_en step %0d", tag, s));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        repeat (3) @(negedge clk);
        // R3: outputs with taps held at rest, gclk low, cs and we low
        check_cfg(-1, PA, SA, 1'b1, pa_n, wla, saa, wra, "R3 rw");
        check_cfg(-1, PB, SB, 1'b0, pb_n, wlb, sab, wrb, "R3 single");
        rst_n = 1'b1;
        for (int s = 0; s < STEPS; s++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            if (lfsr[3:2] == 2'b00) gclk = ~gclk;
            gclk_n = (s % 5 == 4) ? lfsr[9] : ~gclk;
            cs = lfsr[5] | lfsr[6];
            we = lfsr[7];
            hist[s] = {31'd0, gclk};
            @(posedge clk);
            @(negedge clk);
            check_cfg(s, PA, SA, 1'b1, pa_n, wla, saa, wra, "rw");
            check_cfg(s, PB, SB, 1'b0, pb_n, wlb, sab, wrb, "single");
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule